// File: doc/BRIEF.md
# Strap-Configured Clock-Enable Generator

This block lives in the 300 MHz domain fed by the on-chip PLL. It produces single-cycle clock-enable pulses for three consumers: a processor domain, a 100 MHz bus domain and a 50 MHz peripheral domain. The bus and peripheral enables are fixed divide-by-3 and divide-by-6 cadences. The processor cadence is set by a two-bit strap, which the block captures once, right after reset is released. Every PLL-derived divider restarts from a common phase, so all three enables fire together on each 50 MHz boundary and the domains stay synchronous.

A power-up lock timer counts reference-clock periods. Each reference period is one tick every `PLL_MHZ*1000/REF_KHZ` fast cycles. No PLL-derived enable leaves the block until the timer has covered `LOCK_US` microseconds with the lock input held high. A lock indication reports when the timer has expired and lock is still present. Losing lock silences the enables at once and restarts the timer.

Two test paths can take the place of the PLL path. A bypass select routes an externally supplied enable onto all outputs. A scan select routes a scan enable onto all outputs and takes priority over bypass.

Top module: `clkEnGen`

## Requirements
- R1: While `rstN` is low, `cpuEn`, `busEn`, `perEn`, `cpuBusMark`, `lockState` and `cfgErr` are all 0.
- R2: In PLL mode (`scanMode`=0, `bypassSel`=0), no enable pulses until `pllLocked` has been high for `LOCK_US*REF_KHZ/1000` reference ticks. Each tick is `PLL_MHZ*1000/REF_KHZ` fast cycles. The first pulses appear on the cycle after that count completes.
- R3: `lockState` is 1 exactly while the lock timer has expired and `pllLocked` is 1. It follows `pllLocked` falling without delay.
- R4: When `pllLocked` goes low, the PLL-derived enables are 0 from the next clock edge on. The lock timer restarts from zero, and the full R2 delay applies again once `pllLocked` returns.
- R5: In PLL mode with lock valid, `busEn` pulses once every 3 cycles and `perEn` pulses once every 6 cycles.
- R6: The captured strap sets the `cpuEn` spacing: 2'b00 gives one pulse every 6 cycles, 2'b01 every 3 cycles, and 2'b10 every 2 cycles.
- R7: The reserved strap 2'b11 gives `cpuEn` every 6 cycles. It also sets `cfgErr` to 1, which stays 1 until the next reset, including across loss of lock.
- R8: The first PLL-derived pulse after lock has `cpuEn`, `busEn` and `perEn` all high together. Every later `perEn` pulse coincides with `busEn` and `cpuEn`.
- R9: `cpuBusMark` is 1 exactly in the cycles where `cpuEn` and `busEn` are both 1.
- R10: The strap is captured at the first clock edge after `rstN` is released. Later changes on `strapSel` have no effect on the `cpuEn` spacing or on `cfgErr`.
- R11: With `scanMode`=0 and `bypassSel`=1, all four enable outputs equal `extEn` delayed by one cycle, whatever the state of `pllLocked` or the lock timer.
- R12: With `scanMode`=1, all four enable outputs equal `scanEn` delayed by one cycle. This overrides `bypassSel` and `extEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 300 MHz PLL-output clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapSel | input | 2 | Processor-rate strap, captured after reset |
| pllLocked | input | 1 | Live lock indication from the PLL |
| bypassSel | input | 1 | Selects the external enable path |
| extEn | input | 1 | Externally supplied enable used in bypass |
| scanMode | input | 1 | Selects the scan enable path (highest priority) |
| scanEn | input | 1 | Scan-test enable |
| cpuEn | output | 1 | Processor-domain clock enable |
| busEn | output | 1 | 100 MHz bus-domain clock enable |
| perEn | output | 1 | 50 MHz peripheral-domain clock enable |
| cpuBusMark | output | 1 | Marks processor pulses that fall on a bus edge |
| lockState | output | 1 | Timer expired and lock present |
| cfgErr | output | 1 | Sticky reserved-strap flag |

## Verification
The assertions assume that `pllLocked`, `bypassSel`, `scanMode`, `extEn`, `scanEn` and `strapSel` are already synchronous to `clk`. They also assume the selects change only between whole test phases, so the spacing checks are qualified by the registered PLL-mode flag. The stimulus changes every input half a cycle away from the sampling edge. It toggles the lock input only inside PLL mode, and it switches to the bypass and scan paths only after lock is gone. The strap is moved a few cycles after capture, to show that it is ignored rather than to violate the capture rule.

// File: rtl/clkEnPkg.sv
package clkEnPkg;

  localparam int SLOW_DIV = 6;
  localparam int BUS_DIV  = 3;
  localparam int MID_DIV  = 3;
  localparam int FAST_DIV = 2;

  typedef enum logic [1:0] {
    SRC_PLL    = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_SCAN   = 2'd2
  } clkSrc_t;

  typedef enum logic [1:0] {
    RATIO_DIV6 = 2'd0,
    RATIO_DIV3 = 2'd1,
    RATIO_DIV2 = 2'd2
  } cpuRatio_t;

  typedef struct packed {
    logic      valid;
    clkSrc_t   src;
    cpuRatio_t ratio;
    logic      directEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/clkEnLockTimer.sv
module clkEnLockTimer #(
  parameter int REF_DIV    = 24,
  parameter int LOCK_TICKS = 8125
) (
  input  logic clk,
  input  logic rstN,
  input  logic pllLocked,
  output logic timerDone
);

  localparam int REF_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int CNT_W = $clog2(LOCK_TICKS + 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(LOCK_TICKS);

  logic [REF_W-1:0] refCnt;
  logic [CNT_W-1:0] lockCnt;
  logic             refTick;

  assign refTick   = (refCnt == REF_LAST);
  assign timerDone = (lockCnt == CNT_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt  <= '0;
      lockCnt <= '0;
    end else if (!pllLocked) begin
      refCnt  <= '0;
      lockCnt <= '0;
    end else if (!timerDone) begin
      refCnt <= refTick ? '0 : refCnt + 1'b1;
      if (refTick) lockCnt <= lockCnt + 1'b1;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    lockCnt <= CNT_DONE); // R2

  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !pllLocked |=> (lockCnt == '0)); // R4

endmodule

// File: rtl/clkEnCtrl.sv
module clkEnCtrl
  import clkEnPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   strapSel,
  input  logic         timerDone,
  input  logic         pllLocked,
  input  logic         bypassSel,
  input  logic         extEn,
  input  logic         scanMode,
  input  logic         scanEn,
  output ctrlStrobes_t strobes,
  output logic         lockState,
  output logic         cfgErr
);

  logic [1:0] strapQ;
  logic       strapLatched;
  cpuRatio_t  ratio;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ       <= 2'b00;
      strapLatched <= 1'b0;
      cfgErr       <= 1'b0;
    end else if (!strapLatched) begin
      strapQ       <= strapSel;
      strapLatched <= 1'b1;
      cfgErr       <= (strapSel == 2'b11);
    end
  end

  always_comb begin
    unique case (strapQ)
      2'b01:   ratio = RATIO_DIV3;
      2'b10:   ratio = RATIO_DIV2;
      default: ratio = RATIO_DIV6;
    endcase
  end

  assign lockState = timerDone && pllLocked;

  always_comb begin
    strobes.valid = lockState;
    strobes.ratio = ratio;
    if (scanMode) begin
      strobes.src      = SRC_SCAN;
      strobes.directEn = scanEn;
    end else if (bypassSel) begin
      strobes.src      = SRC_BYPASS;
      strobes.directEn = extEn;
    end else begin
      strobes.src      = SRC_PLL;
      strobes.directEn = extEn;
    end
  end

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strapLatched |=> $stable(strapQ)); // R10

  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr); // R7

  AST_LOCK_REPORT: assert property (@(posedge clk) disable iff (!rstN)
    !pllLocked |-> !lockState); // R3

endmodule

// File: rtl/clkEnDatapath.sv
module clkEnDatapath
  import clkEnPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic         cpuEn,
  output logic         busEn,
  output logic         perEn,
  output logic         cpuBusMark
);

  localparam int PHASE_W = $clog2(SLOW_DIV);
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(SLOW_DIV - 1);

  logic [PHASE_W-1:0] phase;
  logic               runPll;
  logic               cpuHit;
  logic               busHit;
  logic               perHit;
  logic               modePllQ;

  assign runPll = (strobes.src == SRC_PLL) && strobes.valid;
  assign busHit = ((int'(phase) % BUS_DIV) == 0);
  assign perHit = (phase == '0);

  always_comb begin
    unique case (strobes.ratio)
      RATIO_DIV3: cpuHit = ((int'(phase) % MID_DIV) == 0);
      RATIO_DIV2: cpuHit = ((int'(phase) % FAST_DIV) == 0);
      default:    cpuHit = perHit;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        phase <= '0;
    else if (!runPll) phase <= '0;
    else              phase <= (phase == PHASE_LAST) ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuEn      <= 1'b0;
      busEn      <= 1'b0;
      perEn      <= 1'b0;
      cpuBusMark <= 1'b0;
      modePllQ   <= 1'b0;
    end else begin
      modePllQ <= (strobes.src == SRC_PLL);
      if (strobes.src == SRC_PLL) begin
        cpuEn      <= runPll && cpuHit;
        busEn      <= runPll && busHit;
        perEn      <= runPll && perHit;
        cpuBusMark <= runPll && cpuHit && busHit;
      end else begin
        cpuEn      <= strobes.directEn;
        busEn      <= strobes.directEn;
        perEn      <= strobes.directEn;
        cpuBusMark <= strobes.directEn;
      end
    end
  end

  AST_NO_EARLY_EN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.src == SRC_PLL && !strobes.valid) |=> !(cpuEn || busEn || perEn)); // R2

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (modePllQ && perEn) |-> (busEn && cpuEn)); // R8

  AST_BUS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (modePllQ && busEn) |=> (!busEn || !modePllQ)); // R5

  AST_MARK: assert property (@(posedge clk) disable iff (!rstN)
    cpuBusMark |-> (cpuEn && busEn)); // R9

  AST_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.src != SRC_PLL) |=> (perEn == $past(strobes.directEn))); // R11

endmodule

// File: rtl/clkEnGen.sv
module clkEnGen
  import clkEnPkg::*;
#(
  parameter int PLL_MHZ = 300,
  parameter int REF_KHZ = 12500,
  parameter int LOCK_US = 650
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] strapSel,
  input  logic       pllLocked,
  input  logic       bypassSel,
  input  logic       extEn,
  input  logic       scanMode,
  input  logic       scanEn,
  output logic       cpuEn,
  output logic       busEn,
  output logic       perEn,
  output logic       cpuBusMark,
  output logic       lockState,
  output logic       cfgErr
);

  localparam int REF_DIV    = (PLL_MHZ * 1000) / REF_KHZ;
  localparam int LOCK_TICKS = (REF_KHZ * LOCK_US) / 1000;

  ctrlStrobes_t strobes;
  logic         timerDone;

  clkEnLockTimer #(
    .REF_DIV    (REF_DIV),
    .LOCK_TICKS (LOCK_TICKS)
  ) i_lockTimer (
    .clk       (clk),
    .rstN      (rstN),
    .pllLocked (pllLocked),
    .timerDone (timerDone)
  );

  clkEnCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .strapSel  (strapSel),
    .timerDone (timerDone),
    .pllLocked (pllLocked),
    .bypassSel (bypassSel),
    .extEn     (extEn),
    .scanMode  (scanMode),
    .scanEn    (scanEn),
    .strobes   (strobes),
    .lockState (lockState),
    .cfgErr    (cfgErr)
  );

  clkEnDatapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cpuEn      (cpuEn),
    .busEn      (busEn),
    .perEn      (perEn),
    .cpuBusMark (cpuBusMark)
  );

endmodule

// File: tb/test_clkEnGen.sv
`timescale 1ns/1ps
module test_clkEnGen;

  localparam time CLK_PERIOD = 4ns;
  localparam int  LOCK_US_TB = 4;
  localparam int  LOCK_CYC   = 1200;  // 50 ticks of 24 cycles
  localparam int  MEAS_CYC   = 36;

  // {strap, cpu spacing, expected cfgErr}
  localparam logic [6:0] VEC [4] = '{
    {2'b00, 4'd6, 1'b0},
    {2'b01, 4'd3, 1'b0},
    {2'b10, 4'd2, 1'b0},
    {2'b11, 4'd6, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] strapSel = 2'b00;
  logic       pllLocked = 1'b0;
  logic       bypassSel = 1'b0;
  logic       extEn = 1'b0;
  logic       scanMode = 1'b0;
  logic       scanEn = 1'b0;
  logic       cpuEn, busEn, perEn, cpuBusMark, lockState, cfgErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  clkEnGen #(.LOCK_US(LOCK_US_TB)) i_clkEnGen (
    .clk(clk), .rstN(rstN), .strapSel(strapSel), .pllLocked(pllLocked),
    .bypassSel(bypassSel), .extEn(extEn), .scanMode(scanMode), .scanEn(scanEn),
    .cpuEn(cpuEn), .busEn(busEn), .perEn(perEn), .cpuBusMark(cpuBusMark),
    .lockState(lockState), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic bit anyEn();
    return cpuEn || busEn || perEn || cpuBusMark;
  endfunction

  // Counts samples until the first enable; also moves the strap after capture.
  task automatic waitFirst(input logic [1:0] strapAfter, output int n);
    n = 0;
    while (n < LOCK_CYC + 50) begin
      @(negedge clk);
      n++;
      if (n == 3) strapSel = strapAfter;
      if (n == 100) chk("R3 lockState low during timer", int'(lockState), 0);
      if (anyEn()) break;
    end
  endtask

  task automatic measure(input int div, input string cpuTag);
    int cpuBad = 0, busBad = 0, perBad = 0, markBad = 0;
    for (int i = 1; i <= MEAS_CYC; i++) begin
      @(negedge clk);
      if (cpuEn != ((i % div) == 0)) cpuBad++;
      if (busEn != ((i % 3) == 0)) busBad++;
      if (perEn != ((i % 6) == 0)) perBad++;
      if (cpuBusMark != (((i % div) == 0) && ((i % 3) == 0))) markBad++;
    end
    chk({cpuTag, " R10 cpuEn spacing mismatches"}, cpuBad, 0);
    chk("R5 busEn spacing mismatches", busBad, 0);
    chk("R5 perEn spacing mismatches", perBad, 0);
    chk("R9 cpuBusMark mismatches", markBad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    for (int v = 0; v < 4; v++) begin
      logic [1:0] strap;
      int         div;
      logic       expErr;
      string      cpuTag;
      strap  = VEC[v][6:5];
      div    = int'(VEC[v][4:1]);
      expErr = VEC[v][0];
      cpuTag = (strap == 2'b11) ? "R7" : "R6";

      @(negedge clk);
      rstN = 1'b0; strapSel = strap; pllLocked = 1'b1;
      bypassSel = 1'b0; scanMode = 1'b0; extEn = 1'b0; scanEn = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 outputs in reset",
          int'({cpuEn, busEn, perEn, cpuBusMark, lockState, cfgErr}), 0);
      rstN = 1'b1;

      waitFirst(~strap, n);
      chk("R2 first enable inside lock window", int'(n >= LOCK_CYC - 2 && n <= LOCK_CYC + 4), 1);
      chk("R3 lockState at first pulse", int'(lockState), 1);
      chk("R8 first pulse aligned", int'({cpuEn, busEn, perEn}), 7);
      chk("R7 cfgErr for strap", int'(cfgErr), int'(expErr));
      measure(div, cpuTag);

      // loss of lock
      pllLocked = 1'b0;
      #1;
      chk("R3 lockState follows lock loss", int'(lockState), 0);
      @(negedge clk);
      chk("R4 enables off after lock loss", int'(anyEn()), 0);
      repeat (4) @(negedge clk);
      pllLocked = 1'b1;
      waitFirst(~strap, n);
      chk("R4 timer restarted after relock", int'(n >= LOCK_CYC - 2 && n <= LOCK_CYC + 4), 1);
      chk("R8 relock pulse aligned", int'({cpuEn, busEn, perEn}), 7);
      chk("R7 cfgErr kept across lock loss", int'(cfgErr), int'(expErr));
    end

    // bypass path, no lock present
    begin
      logic [7:0] pat = 8'b1011_0010;
      int bad = 0;
      @(negedge clk);
      pllLocked = 1'b0; bypassSel = 1'b1; extEn = pat[0];
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if ({cpuEn, busEn, perEn, cpuBusMark} != {4{pat[k]}}) bad++;
        if (k < 7) extEn = pat[k+1];
      end
      chk("R11 bypass follows extEn", bad, 0);
    end

    // scan path overrides bypass
    begin
      logic [7:0] pat = 8'b0100_1101;
      int bad = 0;
      extEn = 1'b1; scanMode = 1'b1; scanEn = pat[0];
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if ({cpuEn, busEn, perEn, cpuBusMark} != {4{pat[k]}}) bad++;
        if (k < 7) scanEn = pat[k+1];
      end
      chk("R12 scan follows scanEn", bad, 0);
    end

    finishRun();
  end

endmodule